// File: doc/BRIEF.md
# Single-Edge Nibble Frame Transmitter

This block turns a parallel word into single-edge nibble frames on one serial pin. Every frame starts with a calibration pulse of fixed length. A status nibble follows, then between one and six data nibbles, an optional check nibble and an optional padding pulse. Each pulse opens with a short phase at the level opposite to idle, and the line then returns to idle for the rest of the pulse. A pulse carries its value in its length, counted in ticks of a timebase. That timebase runs either at the clock rate or at a quarter of it.

The block can run in two ways. In the free-running way it sends frames back to back for as long as it is enabled. In the triggered way it sends one frame for each trigger pulse. At the start of each frame it captures its settings and its data word, so the host may prepare the next frame while the current one is on the wire. A one-cycle completion strobe marks the end of every frame.

Top module: `sent_frame_tx`

## Requirements
- R1: While `en_i` is low, `busy_o` is low, no frame is sent, and from the next clock `tx_o` sits at the idle level. Dropping `en_i` during a frame abandons that frame, and no `done_o` strobe follows.
- R2: A frame is made of pulses in this order: a 56-tick sync pulse, then the status nibble `data_i[27:24]`, then data nibbles taken from `data_i[23:20]` downward (`data_i[23:20]` goes first, `data_i[19:16]` second, and so on). A nibble of value v lasts 12+v ticks.
- R3: Each pulse begins with exactly 5 ticks at the active level, which is the complement of the idle level. The line stays at idle for the remaining ticks of the pulse.
- R4: The idle level of `tx_o` is high when `idle_low_i`=0 and low when `idle_low_i`=1. After reset, `tx_o` is high.
- R5: When `crc_en_i`=1, a check nibble follows the last data nibble. Its value is computed as follows: start from 4'b0101. Fold in each data nibble in sending order, then one extra zero nibble. Each fold XORs the nibble into the value and then performs four left shifts; whenever a 1 leaves bit 3, the shifted value is XORed with 4'b1101. When `crc_en_i`=0, no check nibble is sent.
- R6: When `pause_en_i`=1, a pause pulse ends the frame. Its length is `frame_len_i` minus the ticks already sent in the frame, but never less than 12 ticks. When `pause_en_i`=0, no pause pulse is sent.
- R7: When `div4_i`=0, one tick lasts one clock. When `div4_i`=1, one tick lasts four clocks.
- R8: `nib_cnt_i` selects 1 to 6 data nibbles. The codes 3'b000 and 3'b111 start no frame. A trigger that arrives while such a code is set is consumed and does not produce a frame later.
- R9: With `trig_mode_i`=0 and `en_i`=1, frames follow each other with no gap, and `busy_o` stays high between them.
- R10: With `trig_mode_i`=1, each trigger pulse on `trig_i` sent while idle produces exactly one frame. A trigger received while `busy_o` is high is ignored.
- R11: The polarity, check, pause, prescale, nibble-count, frame-length and data inputs are captured when a frame starts. Changing them during a frame affects only the next frame.
- R12: `done_o` is high for exactly one clock, on the clock at which the last tick of a frame has finished. In triggered mode, `busy_o` falls on that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| trig_mode_i | input | 1 | 1 = one frame per trigger, 0 = free-running |
| idle_low_i | input | 1 | 1 = idle level low, 0 = idle level high |
| crc_en_i | input | 1 | Append the check nibble |
| pause_en_i | input | 1 | Append the padding pulse |
| div4_i | input | 1 | Tick = four clocks when 1, one clock when 0 |
| nib_cnt_i | input | 3 | Number of data nibbles (1 to 6) |
| frame_len_i | input | 10 | Target frame length in ticks when padding is on |
| data_i | input | 28 | Status nibble [27:24] and data nibbles [23:0] |
| trig_i | input | 1 | Frame request pulse |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle end-of-frame strobe |
| tx_o | output | 1 | Serial output |

## Verification
The bench builds the block with its defaults: six nibbles at most, a 10-bit frame-length field, and a prescale factor of four. These values cover the longest frames, the 1:4 tick spacing and both reserved count codes. A frame-length field as large as 1000 lets the padding pulse reach several hundred ticks. A zero field forces the 12-tick minimum. The bench measures every pulse and every active phase between active edges at the pin and checks them against lengths computed from the data word. This means a wrong check nibble, ordering, prescale or padding shows up as a length mismatch.

// File: rtl/sent_tx_pkg.sv
package sent_tx_pkg;

  typedef enum logic [2:0] {
    P_SYNC  = 3'd0,
    P_STAT  = 3'd1,
    P_DATA  = 3'd2,
    P_CRC   = 3'd3,
    P_PAUSE = 3'd4
  } pulse_e;

  localparam int unsigned SYNC_TICKS = 56;
  localparam int unsigned NIB_BASE   = 12;
  localparam int unsigned ACT_TICKS  = 5;
  localparam int unsigned PAUSE_MIN  = 12;
  localparam logic [3:0]  CRC_SEED   = 4'b0101;
  localparam logic [3:0]  CRC_POLY   = 4'b1101;

  // one nibble folded into the running check value, msb first
  function automatic logic [3:0] crc_fold(input logic [3:0] acc, input logic [3:0] nib);
    logic [3:0] c;
    c = acc ^ nib;
    for (int b = 0; b < 4; b++) begin
      c = c[3] ? ({c[2:0], 1'b0} ^ CRC_POLY) : {c[2:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/sent_tick_gen.sv
module sent_tick_gen #(
  parameter int PRESC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic div_i,
  output logic tick_o
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = en_i && div_i;
  assign tick_o = en_i && (!div_i || (cnt_q == LAST));

  always_comb begin
    cnt_d = cnt_q;
    if (!cnt_en)            cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: in divided mode two ticks are never adjacent
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i && $past(div_i) && tick_o) |-> !$past(tick_o));

endmodule

// File: rtl/sent_crc4.sv
module sent_crc4 #(
  parameter int MAX_NIB = 6,
  parameter int NIB_W   = 3,
  parameter int DW      = 28
) (
  input  logic [DW-1:0]    data_i,
  input  logic [NIB_W-1:0] nib_cnt_i,
  output logic [3:0]       crc_o
);
  import sent_tx_pkg::*;

  always_comb begin
    logic [3:0] acc;
    acc = CRC_SEED;
    for (int i = 0; i < MAX_NIB; i++) begin
      if (NIB_W'(i) < nib_cnt_i) acc = crc_fold(acc, data_i[4*(MAX_NIB-1-i) +: 4]);
    end
    crc_o = crc_fold(acc, 4'h0);
  end

endmodule

// File: rtl/sent_tx_seq.sv
module sent_tx_seq #(
  parameter int MAX_NIB = 6,
  parameter int LEN_W   = 10,
  parameter int NIB_W   = 3,
  parameter int DW      = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en_i,
  input  logic             trig_mode_i,
  input  logic             trig_i,
  input  logic             idle_low_i,
  input  logic             crc_en_i,
  input  logic             pause_en_i,
  input  logic             div4_i,
  input  logic [NIB_W-1:0] nib_cnt_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [DW-1:0]    data_i,
  input  logic [3:0]       crc_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             tx_o,
  output logic             div4_o
);
  import sent_tx_pkg::*;

  // state
  logic             busy_q, busy_d, done_q, done_d, tx_q, tx_d, pend_q, pend_d;
  pulse_e           kind_q, kind_d;
  logic [NIB_W-1:0] nib_q, nib_d;
  logic [LEN_W-1:0] len_q, len_d, cnt_q, cnt_d, el_q, el_d;
  // frame settings captured at start
  logic             c_il, c_crc, c_pau, c_div;
  logic [NIB_W-1:0] c_nib;
  logic [LEN_W-1:0] c_flen;
  logic [DW-1:0]    c_data;
  logic [3:0]       c_crcv;

  logic             nib_ok, start;
  pulse_e           nx_kind;
  logic [NIB_W-1:0] nx_nib;
  logic [LEN_W-1:0] nx_len, p_len;
  logic             nx_end;

  function automatic logic [3:0] pick(input logic [DW-1:0] d, input logic [NIB_W:0] k);
    logic [3:0] r;
    r = '0;
    for (int i = 0; i < MAX_NIB; i++) if (k == (NIB_W+1)'(i)) r = d[4*(MAX_NIB-1-i) +: 4];
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] nib_len(input logic [3:0] v);
    return LEN_W'(NIB_BASE) + LEN_W'(v);
  endfunction

  assign nib_ok = (nib_cnt_i != '0) && (nib_cnt_i <= NIB_W'(MAX_NIB));

  // pulse that follows the current one
  always_comb begin
    logic [LEN_W:0] need;
    need   = {1'b0, el_q} + (LEN_W+1)'(PAUSE_MIN);
    p_len  = ({1'b0, c_flen} >= need) ? (c_flen - el_q) : LEN_W'(PAUSE_MIN);
    nx_kind = kind_q;
    nx_nib  = nib_q;
    nx_len  = '0;
    nx_end  = 1'b0;
    case (kind_q)
      P_SYNC: begin
        nx_kind = P_STAT;
        nx_len  = nib_len(c_data[DW-1 -: 4]);
      end
      P_STAT: begin
        nx_kind = P_DATA;
        nx_nib  = '0;
        nx_len  = nib_len(pick(c_data, '0));
      end
      P_DATA: begin
        if (({1'b0, nib_q} + 1'b1) < {1'b0, c_nib}) begin
          nx_nib = nib_q + 1'b1;
          nx_len = nib_len(pick(c_data, {1'b0, nib_q} + 1'b1));
        end else if (c_crc) begin
          nx_kind = P_CRC;
          nx_len  = nib_len(c_crcv);
        end else if (c_pau) begin
          nx_kind = P_PAUSE;
          nx_len  = p_len;
        end else begin
          nx_end = 1'b1;
        end
      end
      P_CRC: begin
        if (c_pau) begin
          nx_kind = P_PAUSE;
          nx_len  = p_len;
        end else begin
          nx_end = 1'b1;
        end
      end
      default: nx_end = 1'b1;
    endcase
  end

  // next state
  always_comb begin
    busy_d = busy_q; done_d = 1'b0; tx_d = tx_q; pend_d = pend_q;
    kind_d = kind_q; nib_d = nib_q; len_d = len_q; cnt_d = cnt_q; el_d = el_q;
    start  = 1'b0;
    if (!en_i) begin
      busy_d = 1'b0;
      tx_d   = !idle_low_i;
      pend_d = 1'b0;
    end else if (!busy_q) begin
      tx_d   = !idle_low_i;
      pend_d = trig_mode_i && ((pend_q && !tick) || trig_i);
      if (tick && nib_ok && (!trig_mode_i || pend_q)) start = 1'b1;
    end else begin
      pend_d = 1'b0;
      if (tick) begin
        el_d = el_q + 1'b1;
        if (cnt_q == len_q) begin
          if (nx_end) begin
            done_d = 1'b1;
            if (!trig_mode_i && nib_ok) begin
              start = 1'b1;
            end else begin
              busy_d = 1'b0;
              tx_d   = !c_il;
            end
          end else begin
            kind_d = nx_kind;
            nib_d  = nx_nib;
            len_d  = nx_len;
            cnt_d  = LEN_W'(1);
            tx_d   = c_il;
          end
        end else begin
          tx_d  = (cnt_q < LEN_W'(ACT_TICKS)) ? c_il : !c_il;
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
    if (start) begin
      busy_d = 1'b1;
      kind_d = P_SYNC;
      nib_d  = '0;
      len_d  = LEN_W'(SYNC_TICKS);
      cnt_d  = LEN_W'(1);
      el_d   = LEN_W'(1);
      tx_d   = idle_low_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; tx_q <= 1'b1; pend_q <= 1'b0;
      kind_q <= P_SYNC; nib_q <= '0; len_q <= '0; cnt_q <= '0; el_q <= '0;
    end else begin
      busy_q <= busy_d; done_q <= done_d; tx_q <= tx_d; pend_q <= pend_d;
      kind_q <= kind_d; nib_q <= nib_d; len_q <= len_d; cnt_q <= cnt_d; el_q <= el_d;
    end
  end

  // settings register, loaded only on frame start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_il <= 1'b0; c_crc <= 1'b0; c_pau <= 1'b0; c_div <= 1'b0;
      c_nib <= '0; c_flen <= '0; c_data <= '0; c_crcv <= '0;
    end else if (start) begin
      c_il <= idle_low_i; c_crc <= crc_en_i; c_pau <= pause_en_i; c_div <= div4_i;
      c_nib <= nib_cnt_i; c_flen <= frame_len_i; c_data <= data_i; c_crcv <= crc_i;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign tx_o   = tx_q;
  assign div4_o = c_div;

  a_r1_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!busy_q && (tx_q == !$past(idle_low_i))));
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r8_reserved_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !nib_ok) |=> !busy_q);
  a_r10_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && trig_mode_i && !pend_q) |=> !busy_q);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((cnt_q != '0) && (cnt_q <= len_q)));
  a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !done_q) |-> ($stable(c_nib) && $stable(c_data) && $stable(c_il)));

endmodule

// File: rtl/sent_frame_tx.sv
module sent_frame_tx #(
  parameter int MAX_NIB = 6,
  parameter int LEN_W   = 10,
  parameter int PRESC   = 4,
  localparam int NIB_W  = $clog2(MAX_NIB + 2),
  localparam int DW     = 4 * (MAX_NIB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             trig_mode_i,
  input  logic             idle_low_i,
  input  logic             crc_en_i,
  input  logic             pause_en_i,
  input  logic             div4_i,
  input  logic [NIB_W-1:0] nib_cnt_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [DW-1:0]    data_i,
  input  logic             trig_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             tx_o
);
  logic [1:0] rs_q;
  logic       rst_s_n, tick, div_sel, c_div;
  logic [3:0] crc_val;

  // reset asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  assign div_sel = busy_o ? c_div : div4_i;

  sent_tick_gen #(.PRESC(PRESC)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .en_i(en_i), .div_i(div_sel), .tick_o(tick)
  );

  sent_crc4 #(.MAX_NIB(MAX_NIB), .NIB_W(NIB_W), .DW(DW)) u_crc (
    .data_i(data_i), .nib_cnt_i(nib_cnt_i), .crc_o(crc_val)
  );

  sent_tx_seq #(.MAX_NIB(MAX_NIB), .LEN_W(LEN_W), .NIB_W(NIB_W), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .en_i(en_i), .trig_mode_i(trig_mode_i),
    .trig_i(trig_i), .idle_low_i(idle_low_i), .crc_en_i(crc_en_i), .pause_en_i(pause_en_i),
    .div4_i(div4_i), .nib_cnt_i(nib_cnt_i), .frame_len_i(frame_len_i), .data_i(data_i),
    .crc_i(crc_val), .busy_o(busy_o), .done_o(done_o), .tx_o(tx_o), .div4_o(c_div)
  );

endmodule

// File: tb/sim_sent_frame_tx.sv
`timescale 1ns/1ps
module sim_sent_frame_tx;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en_i = 1'b0, trig_mode_i = 1'b1, idle_low_i = 1'b0, crc_en_i = 1'b0;
  logic        pause_en_i = 1'b0, div4_i = 1'b0, trig_i = 1'b0;
  logic [2:0]  nib_cnt_i = 3'd6;
  logic [9:0]  frame_len_i = '0;
  logic [27:0] data_i = '0;
  logic        busy_o, done_o, tx_o;

  always #2.5 clk = ~clk;

  sent_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .trig_mode_i(trig_mode_i), .idle_low_i(idle_low_i),
    .crc_en_i(crc_en_i), .pause_en_i(pause_en_i), .div4_i(div4_i), .nib_cnt_i(nib_cnt_i),
    .frame_len_i(frame_len_i), .data_i(data_i), .trig_i(trig_i),
    .busy_o(busy_o), .done_o(done_o), .tx_o(tx_o)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- pin monitor ----------------
  logic mon_act = 1'b0;
  int   mon_div = 1;
  int   cyc = 0, act_start = 0, cur_n = 0, fr_n = 0, frames = 0, cur_bad = 0, fr_bad = 0;
  int   cur_len[16], fr_len[16];
  int   done_run = 0, busy_falls = 0, busy_rises = 0;
  bit   done_long = 0, in_frame = 0;
  logic prev_tx = 1'b1, prev_busy = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (done_o) begin done_run++; if (done_run > 1) done_long = 1; end
    else done_run = 0;
    if (prev_busy && !busy_o) busy_falls++;
    if (!prev_busy && busy_o) busy_rises++;
    if (prev_busy && !busy_o && !done_o) in_frame = 0;
    if (done_o && in_frame) begin
      if (cur_n > 0 && cur_n <= 16) cur_len[cur_n-1] = cyc - act_start;
      for (int i = 0; i < 16; i++) fr_len[i] = cur_len[i];
      fr_n = cur_n; fr_bad = cur_bad; frames++; in_frame = 0;
    end
    if (busy_o && tx_o == mon_act && prev_tx != mon_act) begin
      if (!in_frame) begin in_frame = 1; cur_n = 0; cur_bad = 0; end
      else if (cur_n > 0 && cur_n <= 16) cur_len[cur_n-1] = cyc - act_start;
      cur_n++;
      act_start = cyc;
    end
    if (in_frame && tx_o != mon_act && prev_tx == mon_act && (cyc - act_start) != 5 * mon_div)
      cur_bad++;
    prev_tx = tx_o; prev_busy = busy_o;
  end

  // ---------------- model ----------------
  int exp_len[16];
  int exp_n;

  function automatic logic [3:0] tb_fold(input logic [3:0] a, input logic [3:0] x);
    logic [3:0] c;
    c = a ^ x;
    for (int b = 0; b < 4; b++) c = c[3] ? ({c[2:0], 1'b0} ^ 4'b1101) : {c[2:0], 1'b0};
    return c;
  endfunction

  function automatic logic [3:0] tb_crc(input logic [27:0] d, input int n);
    logic [3:0] c;
    c = 4'b0101;
    for (int k = 0; k < n; k++) c = tb_fold(c, d[23-4*k -: 4]);
    return tb_fold(c, 4'h0);
  endfunction

  task automatic calc_exp(input logic [27:0] d, input int n, input bit crc, input bit pau, input int flen);
    int sum;
    exp_len[0] = 56;
    exp_len[1] = 12 + int'(d[27:24]);
    exp_n = 2;
    for (int k = 0; k < n; k++) begin exp_len[exp_n] = 12 + int'(d[23-4*k -: 4]); exp_n++; end
    if (crc) begin exp_len[exp_n] = 12 + int'(tb_crc(d, n)); exp_n++; end
    sum = 0;
    for (int i = 0; i < exp_n; i++) sum += exp_len[i];
    if (pau) begin exp_len[exp_n] = (flen >= sum + 12) ? flen - sum : 12; exp_n++; end
  endtask

  task automatic cmp_frame(input string req);
    chk(fr_n == exp_n, req, "pulse count", fr_n, exp_n);
    for (int i = 0; i < exp_n && i < 16; i++)
      chk(fr_len[i] == exp_len[i] * mon_div, req, $sformatf("pulse %0d clocks", i), fr_len[i], exp_len[i] * mon_div);
    chk(fr_bad == 0, "R3", "active phase width errors", fr_bad, 0);
  endtask

  task automatic wait_frames(input int target, input int limit);
    int t;
    t = 0;
    while (frames < target && t < limit) begin @(negedge clk); t++; end
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
  endtask

  task automatic apply(input bit il, input bit crc, input bit pau, input bit dv, input logic [2:0] n,
                       input logic [9:0] fl, input logic [27:0] d);
    @(negedge clk);
    idle_low_i = il; crc_en_i = crc; pause_en_i = pau; div4_i = dv; nib_cnt_i = n;
    frame_len_i = fl; data_i = d;
    mon_act = il; mon_div = dv ? 4 : 1;
  endtask

  // ---------------- stimulus table ----------------
  typedef struct packed {
    logic        il;
    logic        crc;
    logic        pau;
    logic        dv;
    logic [2:0]  nib;
    logic [9:0]  flen;
    logic [27:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 3'd6, 10'd0,    28'h3A5F09C},   // R2 R5 six nibbles, 1:1
    '{1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 10'd300,  28'hC7E2BAD},   // R4 R6 idle low, padded
    '{1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 10'd0,    28'h0F00000},   // R6 minimum pause, R7 1:4
    '{1'b1, 1'b0, 1'b0, 1'b1, 3'd4, 10'd0,    28'h5012345},   // R7 no crc no pause
    '{1'b0, 1'b1, 1'b1, 1'b1, 3'd5, 10'd1000, 28'hFFFFFFF},   // R6 long pad, all ones
    '{1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 10'd0,    28'h0000000}    // R5 all zeros
  };

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f0, r0, b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk(tx_o == 1'b1, "R4", "tx after reset", tx_o, 1);
    chk(busy_o == 1'b0, "R12", "busy after reset", busy_o, 0);
    chk(done_o == 1'b0, "R12", "done after reset", done_o, 0);
    // disabled, idle low
    idle_low_i = 1'b1;
    @(negedge clk);
    chk(tx_o == 1'b0, "R1", "tx idle low while disabled", tx_o, 0);
    idle_low_i = 1'b0;
    @(negedge clk);
    chk(tx_o == 1'b1, "R4", "tx idle high while disabled", tx_o, 1);
    en_i = 1'b1;

    // table walk in triggered mode
    foreach (VECS[i]) begin
      apply(VECS[i].il, VECS[i].crc, VECS[i].pau, VECS[i].dv, VECS[i].nib, VECS[i].flen, VECS[i].data);
      calc_exp(VECS[i].data, int'(VECS[i].nib), VECS[i].crc, VECS[i].pau, int'(VECS[i].flen));
      repeat (3) @(negedge clk);
      f0 = frames;
      pulse_trig();
      wait_frames(f0 + 1, 9000);
      chk(frames == f0 + 1, "R10", "frame after trigger", frames - f0, 1);
      cmp_frame("R2");
      @(negedge clk);
      chk(tx_o == !VECS[i].il, "R4", "idle level after frame", tx_o, !VECS[i].il);
      chk(busy_o == 1'b0, "R12", "busy after triggered frame", busy_o, 0);
    end

    // R8 reserved codes consume the trigger
    apply(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 10'd0, 28'h1234567);
    f0 = frames; r0 = busy_rises;
    pulse_trig();
    repeat (100) @(negedge clk);
    nib_cnt_i = 3'd7;
    pulse_trig();
    repeat (100) @(negedge clk);
    nib_cnt_i = 3'd2;
    repeat (200) @(negedge clk);
    chk(busy_rises == r0, "R8", "frames started with reserved codes", busy_rises - r0, 0);
    chk(tx_o == 1'b1, "R8", "line idle after reserved trigger", tx_o, 1);

    // R10 second trigger during a frame is ignored
    apply(1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 10'd0, 28'h2480000);
    f0 = frames; r0 = busy_rises;
    pulse_trig();
    repeat (30) @(negedge clk);
    pulse_trig();
    wait_frames(f0 + 1, 2000);
    repeat (400) @(negedge clk);
    chk(busy_rises - r0 == 1, "R10", "frames for two triggers, one mid-frame", busy_rises - r0, 1);

    // R11 changes mid-frame do not alter the current frame
    apply(1'b0, 1'b1, 1'b1, 1'b0, 3'd4, 10'd350, 28'h9876543);
    calc_exp(28'h9876543, 4, 1'b1, 1'b1, 350);
    f0 = frames;
    pulse_trig();
    repeat (40) @(negedge clk);
    data_i = 28'h0000000; nib_cnt_i = 3'd1; crc_en_i = 1'b0; pause_en_i = 1'b0; div4_i = 1'b1;
    wait_frames(f0 + 1, 4000);
    cmp_frame("R11");

    // R9 free-running frames, back to back
    apply(1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 10'd0, 28'hA1B2C3D);
    calc_exp(28'hA1B2C3D, 3, 1'b1, 1'b0, 0);
    repeat (4) @(negedge clk);
    f0 = frames;
    trig_mode_i = 1'b0;
    wait_frames(f0 + 1, 4000);
    b0 = busy_falls;
    wait_frames(f0 + 3, 8000);
    chk(frames == f0 + 3, "R9", "continuous frames seen", frames - f0, 3);
    chk(busy_falls == b0, "R9", "busy drops between frames", busy_falls - b0, 0);
    cmp_frame("R9");
    chk(done_long == 0, "R12", "done longer than one clock", int'(done_long), 0);

    // R1 abort mid-frame
    repeat (50) @(negedge clk);
    f0 = frames;
    en_i = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0, "R1", "busy after disable", busy_o, 0);
    chk(tx_o == 1'b0, "R1", "tx at idle after disable", tx_o, 0);
    repeat (300) @(negedge clk);
    chk(frames == f0, "R1", "done strobes after abort", frames - f0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule